// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the memory address of an operand written as displacement(base, index, scale). The result is base register plus index register times the scale plus a displacement. It takes the current contents of the eight general registers, picks the base and index by 3-bit selectors, and shifts the index left by 0, 1, 2 or 3 places. It then adds a displacement that is absent, one byte, two bytes or four bytes wide. All arithmetic wraps modulo 2^32.

The base, the index and the displacement can each be left out. This covers the short forms: no displacement, no scale (a factor of one), and no base. The stack pointer cannot serve as an index. A request that names it gets an error pulse instead of an address.

The operation is one request strobe with the operand fields held on the same edge. The result is registered. On the next cycle either the address with a one-cycle valid pulse appears, or the error pulse appears.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `ea` is 0 and `ea_valid` and `bad_index` are low.
- R2: A legal request sampled at a clock edge shows `ea = base_term + (index_term << scale_code) + disp_term` (mod 2^32) after that edge, and `ea_valid` is high for exactly that one cycle.
- R3: `scale_code` 0, 1, 2, 3 multiplies the index by 1, 2, 4, 8 respectively.
- R4: `disp_size` 0 adds no displacement, 1 adds `disp[7:0]` sign-extended, 2 adds `disp[15:0]` sign-extended, 3 adds all 32 bits of `disp`.
- R5: With `base_en` low the base term is 0 and `base_sel` is ignored. With `idx_en` low the index term is 0 and `idx_sel` is ignored; this includes selector 4, which then raises no error.
- R6: A request with `idx_en` high and `idx_sel` = 4 (stack pointer) pulses `bad_index` for one cycle, keeps `ea_valid` low and leaves `ea` at its previous value.
- R7: A cycle without a request leaves `ea_valid` and `bad_index` low in the next cycle and `ea` unchanged.
- R8: Register selectors map 0..7 to eax, ecx, edx, ebx, esp, ebp, esi, edi. With edx = 0xF000 and ecx = 0x100, the results are 0x8(edx) = 0xF008, (edx,ecx) = 0xF100 and (edx,ecx,4) = 0xF400. The form 0x80(,edx,2) with a 2-byte displacement gives 0x1E080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe; operand fields are sampled with it |
| regs | input | 8x32 | Register file contents, element i is register selector i |
| base_en | input | 1 | Base register is present |
| base_sel | input | 3 | Base register selector |
| idx_en | input | 1 | Index register is present |
| idx_sel | input | 3 | Index register selector |
| scale_code | input | 2 | Index shift amount (factor 1, 2, 4, 8) |
| disp | input | 32 | Displacement bits |
| disp_size | input | 2 | 0 none, 1 byte, 2 halfword, 3 word |
| ea | output | 32 | Registered effective address |
| ea_valid | output | 1 | One-cycle pulse: `ea` holds a new address |
| bad_index | output | 1 | One-cycle pulse: stack pointer named as index |

## Verification
The assertions take the selectors and size codes to be known values whenever `req` is high. They also take `req` to be low during reset, because they look one cycle into the past at the strobe and the index fields. The stimulus keeps to this. It drives every field at the falling edge from a fixed, fully defined pattern, and it holds `req` low through reset and between requests. The sweep runs through every combination of presence flags, selectors, scale codes and size codes. It uses register and displacement values with high bits set, so that sign extension and wrap-around are visible in the sums.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32,
  parameter int NREG = 8,
  parameter int SP_SEL = 4,
  localparam int SELW = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [NREG-1:0][AW-1:0]  regs,
  input  logic                     base_en,
  input  logic [SELW-1:0]          base_sel,
  input  logic                     idx_en,
  input  logic [SELW-1:0]          idx_sel,
  input  logic [1:0]               scale_code,
  input  logic [AW-1:0]            disp,
  input  logic [1:0]               disp_size,
  output logic [AW-1:0]            ea,
  output logic                     ea_valid,
  output logic                     bad_index
);

  logic [AW-1:0] base_term, idx_term, disp_term, sum;
  logic          illegal;

  assign base_term = base_en ? regs[base_sel] : '0;
  assign idx_term  = idx_en ? (regs[idx_sel] << scale_code) : '0;
  assign illegal   = idx_en && (idx_sel == SELW'(SP_SEL));

  always_comb begin
    case (disp_size)
      2'd0:    disp_term = '0;
      2'd1:    disp_term = {{(AW-8){disp[7]}}, disp[7:0]};
      2'd2:    disp_term = {{(AW-16){disp[15]}}, disp[15:0]};
      default: disp_term = disp;
    endcase
  end

  assign sum = base_term + idx_term + disp_term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea        <= '0;
      ea_valid  <= 1'b0;
      bad_index <= 1'b0;
    end else begin
      ea_valid  <= req && !illegal;
      bad_index <= req && illegal;
      if (req && !illegal) ea <= sum;
    end
  end

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 32,
  parameter int SELW = 3,
  parameter int SP_SEL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            idx_en,
  input logic [SELW-1:0] idx_sel,
  input logic [AW-1:0]   ea,
  input logic            ea_valid,
  input logic            bad_index
);

  // R6
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_valid && bad_index));

  // R2
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> $past(req));

  // R6
  err_needs_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_index |-> $past(req && idx_en && idx_sel == SELW'(SP_SEL)));

  // R6
  err_keeps_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_index |-> $stable(ea));

  // R5
  no_index_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !idx_en) |=> !bad_index);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!ea_valid && !bad_index && $stable(ea)));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .SELW(SELW), .SP_SEL(SP_SEL)) chk_i (.*);

// File: tb/ea_gen_tb_top.sv
`timescale 1ns/1ps
module ea_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [7:0][31:0] regs;
  logic base_en = 1'b0, idx_en = 1'b0;
  logic [2:0] base_sel = '0, idx_sel = '0;
  logic [1:0] scale_code = '0, disp_size = '0;
  logic [31:0] disp = '0;
  logic [31:0] ea;
  logic ea_valid, bad_index;

  int checks = 0;
  int failures = 0;
  logic [31:0] last_ea = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ea_gen dut_i (.clk(clk), .rst_n(rst_n), .req(req), .regs(regs),
    .base_en(base_en), .base_sel(base_sel), .idx_en(idx_en), .idx_sel(idx_sel),
    .scale_code(scale_code), .disp(disp), .disp_size(disp_size),
    .ea(ea), .ea_valid(ea_valid), .bad_index(bad_index));

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic be, logic [2:0] bs, logic ie,
      logic [2:0] is, logic [1:0] sc, logic [31:0] d, logic [1:0] ds);
    logic [31:0] b, x, dd;
    b = be ? regs[bs] : 32'd0;
    x = ie ? regs[is] * (32'd1 << sc) : 32'd0;
    case (ds)
      2'd0: dd = 32'd0;
      2'd1: dd = d[7] ? (32'hFFFF_FF00 | {24'd0, d[7:0]}) : {24'd0, d[7:0]};
      2'd2: dd = d[15] ? (32'hFFFF_0000 | {16'd0, d[15:0]}) : {16'd0, d[15:0]};
      default: dd = d;
    endcase
    return b + x + dd;
  endfunction

  task automatic issue(string tag, logic be, logic [2:0] bs, logic ie,
      logic [2:0] is, logic [1:0] sc, logic [31:0] d, logic [1:0] ds);
    logic ill;
    logic [31:0] exp_ea;
    base_en = be; base_sel = bs; idx_en = ie; idx_sel = is;
    scale_code = sc; disp = d; disp_size = ds; req = 1'b1;
    ill = ie && (is == 3'd4);
    exp_ea = ill ? last_ea : model(be, bs, ie, is, sc, d, ds);
    @(negedge clk);
    req = 1'b0;
    check(tag, {ea_valid, bad_index, ea}, {!ill, ill, exp_ea});
    last_ea = exp_ea;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 32'h9E37_79B9 * (i + 1) + 32'(i);
    repeat (3) @(negedge clk);
    check("R1 in reset", {ea_valid, bad_index, ea}, 34'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {ea_valid, bad_index, ea}, 34'd0);

    for (int m = 0; m < 4; m++)
      for (int bs = 0; bs < 8; bs++)
        for (int is = 0; is < 8; is++)
          for (int sc = 0; sc < 4; sc++)
            for (int ds = 0; ds < 4; ds++) begin
              logic [31:0] d;
              d = 32'hF000_0000 ^ (32'((bs * 8 + is) * 16 + sc * 4 + ds) * 32'h0101_0183);
              issue("R2 R3 R4 R5 R6 sweep", m[0], 3'(bs), m[1], 3'(is),
                    2'(sc), d, 2'(ds));
            end

    @(negedge clk);
    check("R7 idle hold", {ea_valid, bad_index, ea}, {2'b00, last_ea});

    issue("R6 stack index", 1'b1, 3'd0, 1'b1, 3'd4, 2'd3, 32'h1234, 2'd3);
    issue("R5 stack sel ignored", 1'b1, 3'd0, 1'b0, 3'd4, 2'd3, 32'h1234, 2'd3);

    regs[2] = 32'h0000_F000;
    regs[1] = 32'h0000_0100;
    issue("R8 disp only", 1'b1, 3'd2, 1'b0, 3'd0, 2'd0, 32'h8, 2'd1);
    check("R8 F008", {2'b00, ea}, {2'b00, 32'h0000_F008});
    issue("R8 base index", 1'b1, 3'd2, 1'b1, 3'd1, 2'd0, 32'h0, 2'd0);
    check("R8 F100", {2'b00, ea}, {2'b00, 32'h0000_F100});
    issue("R8 scale4", 1'b1, 3'd2, 1'b1, 3'd1, 2'd2, 32'h0, 2'd0);
    check("R8 F400", {2'b00, ea}, {2'b00, 32'h0000_F400});
    issue("R8 no base", 1'b0, 3'd7, 1'b1, 3'd2, 2'd1, 32'h80, 2'd2);
    check("R8 1E080", {2'b00, ea}, {2'b00, 32'h0001_E080});
    issue("R4 byte sign", 1'b0, 3'd7, 1'b1, 3'd2, 2'd1, 32'h80, 2'd1);
    check("R4 1DF80", {2'b00, ea}, {2'b00, 32'h0001_DF80});
    regs[3] = 32'hFFFF_FFF0;
    issue("R2 wrap", 1'b1, 3'd3, 1'b0, 3'd0, 2'd0, 32'h20, 2'd3);
    check("R2 wrap value", {2'b00, ea}, {2'b00, 32'h0000_0010});
    @(negedge clk);
    check("R2 one-cycle valid", {ea_valid, bad_index}, 34'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule